// File: doc/BRIEF.md
# Direct-Mapped Cache with Selectable Store Policy

The block is a direct-mapped data cache that sits between a processor request port and a simple word-wide main-memory port. Each byte address is cut into three unsigned fields. The low bits pick a byte and a word inside a block. The middle bits pick one line. The remaining high bits form the tag. Every line keeps a valid flag, a dirty flag, a stored tag and a block of `LINE_WORDS` words. A read that hits returns the addressed word with no memory traffic. A read miss fetches the whole block from memory in ascending word order, replaces the line and returns the word.

How stores behave is fixed at elaboration by two parameters. `WRITE_BACK` chooses between write-through and write-back. `WRITE_ALLOC` chooses whether a store miss allocates the line. In write-back mode a modified line is copied out to memory as a full block before its replacement is fetched. Two counters report how many completed accesses hit and how many missed.

A controller drives the block through five states:
- IDLE accepts a request (IDLE→LOOKUP).
- LOOKUP resolves the request. It can finish (LOOKUP→IDLE), write one word to memory (LOOKUP→MEMWR), copy out a dirty victim (LOOKUP→EVICT) or fetch the block (LOOKUP→FILL).
- EVICT streams the victim block out (EVICT→FILL after its last beat).
- FILL streams the new block in (FILL→LOOKUP after its last beat, where the access now hits).
- MEMWR issues a single word write (MEMWR→IDLE once memory accepts it).

Top module: `dm_cache`

## Requirements
- R1: With the default parameters (32-bit address, 4 words of 32 bits per line, 256 lines), byte offset is addr[1:0], word select is addr[3:2], line index is addr[11:4] and the tag is addr[31:12]. In general the index is the next log2(LINES) bits above the word select, and two addresses with the same index but different tags conflict for one line.
- R2: After reset every line is invalid, both counters read 0, cpu_ready is 1, cpu_done is 0 and mem_valid is 0.
- R3: A lookup to an invalid line is a miss even when the stored tag equals the address tag. Stored tags reset to 0, so a first access with tag 0 must miss.
- R4: A read whose line is valid with an equal tag is a hit. cpu_rdata holds the word chosen by the word-select bits when cpu_done pulses, and no memory transaction takes place.
- R5: A read miss makes exactly LINE_WORDS memory reads (mem_we=0) at block base + 4·k for k ascending from 0. The line then becomes valid with the new tag and clean, and the requested word is returned.
- R6: In write-through mode a store hit updates the cached word and makes exactly one memory write of that word at the store address. Memory then always equals the processor's view.
- R7: In write-back mode a store hit updates only the cached word and marks the line dirty. No memory transaction takes place.
- R8: On a miss to a valid dirty line, the victim block is written out first: LINE_WORDS writes at {old tag, index, k, 00} for k ascending. The fill reads follow. A clean victim is dropped with no write.
- R9: With write-allocate, a store miss fetches the block as in R5 and then updates the word. Write-through then adds one word write, while write-back marks the line dirty.
- R10: With no-write-allocate, a store miss makes exactly one memory write of the word and leaves every line unchanged.
- R11: Only one access is in flight. cpu_ready falls the cycle after a request is accepted and returns with the one-cycle cpu_done pulse. mem_valid is asserted only while cpu_ready is 0.
- R12: Every completed access adds exactly 1 to hit_count or to miss_count, in the cycle cpu_done is high. It counts as a miss if its first lookup missed.
- R13: Once mem_valid is high without mem_ready, mem_valid, mem_addr and mem_we hold their values in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, taken when cpu_ready is 1 |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | WORD_W | Store data |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_done | output | 1 | One-cycle pulse when an access completes |
| cpu_rdata | output | WORD_W | Load result, valid with cpu_done on a load |
| mem_valid | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Word-aligned memory byte address |
| mem_wdata | output | WORD_W | Memory write data |
| mem_ready | input | 1 | Memory accepts the transaction this cycle |
| mem_rdata | input | WORD_W | Read data, sampled when mem_valid and mem_ready are high |
| hit_count | output | CNT_W | Completed accesses that hit |
| miss_count | output | CNT_W | Completed accesses that missed |

## Verification
The bench builds four copies of the cache, each with LINES=16 and every other parameter at its default. They cover all four combinations of WRITE_BACK and WRITE_ALLOC. With only 16 lines and a 2 KB random address window, tag conflicts on one index are frequent. That makes dirty evictions, clean drops and no-allocate store misses common within a few hundred accesses. The random stalls on mem_ready exercise holding a transaction across waits in the middle of both evict and fill bursts.

// File: rtl/dmc_pkg.sv
`timescale 1ns/1ps
package dmc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_EVICT,
        ST_FILL,
        ST_MEMWR
    } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
`timescale 1ns/1ps
module dmc_tag_store #(
    parameter int LINES = 256,
    parameter int TAG_W = 20,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             alloc_en,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic             dirty_set,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag
);
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= '0;
            end
        end else if (alloc_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
            tag_q[idx]   <= alloc_tag;
        end else if (dirty_set) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];
    assign line_tag   = tag_q[idx];
endmodule

// File: rtl/dmc_data_store.sv
`timescale 1ns/1ps
module dmc_data_store #(
    parameter int LINES      = 256,
    parameter int LINE_WORDS = 4,
    parameter int WORD_W     = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(LINE_WORDS)
) (
    input  logic                         clk,
    input  logic [IDX_W-1:0]             idx,
    input  logic                         wr_en,
    input  logic [WSEL_W-1:0]            wr_sel,
    input  logic [WORD_W-1:0]            wr_data,
    output logic [LINE_WORDS*WORD_W-1:0] line_bits
);
    logic [WORD_W-1:0] words_q [LINES][LINE_WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words_q[idx][wr_sel] <= wr_data;
        end
    end

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
        assign line_bits[w*WORD_W +: WORD_W] = words_q[idx][w];
    end
endmodule

// File: rtl/dmc_counters.sv
`timescale 1ns/1ps
module dmc_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump_hit,
    input  logic             bump_miss,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_count  <= '0;
            miss_count <= '0;
        end else begin
            if (bump_hit)  hit_count  <= hit_count + 1'b1;
            if (bump_miss) miss_count <= miss_count + 1'b1;
        end
    end
endmodule

// File: rtl/dm_cache.sv
`timescale 1ns/1ps
module dm_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int WORD_W      = 32,
    parameter int LINE_WORDS  = 4,
    parameter int LINES       = 256,
    parameter int CNT_W       = 16,
    parameter bit WRITE_BACK  = 1'b1,
    parameter bit WRITE_ALLOC = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int BYTE_OFF = $clog2(WORD_W / 8);
    localparam int WSEL_W   = $clog2(LINE_WORDS);
    localparam int OFF_W    = BYTE_OFF + WSEL_W;
    localparam int IDX_W    = $clog2(LINES);
    localparam int TAG_W    = ADDR_W - IDX_W - OFF_W;
    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

    dmc_state_e state, nxt;

    logic [ADDR_W-1:0] r_addr;
    logic              r_we;
    logic [WORD_W-1:0] r_wdata;
    logic              r_miss;
    logic [WSEL_W-1:0] beat;

    logic [TAG_W-1:0]  r_tag;
    logic [IDX_W-1:0]  r_idx;
    logic [WSEL_W-1:0] r_wsel;
    assign r_tag  = r_addr[ADDR_W-1 -: TAG_W];
    assign r_idx  = r_addr[OFF_W +: IDX_W];
    assign r_wsel = r_addr[BYTE_OFF +: WSEL_W];

    logic                         t_valid, t_dirty;
    logic [TAG_W-1:0]             t_tag;
    logic [LINE_WORDS*WORD_W-1:0] line_bits;
    logic                         hit, mem_fire, last_beat, finish;
    logic                         alloc_en, dirty_set, dwr_en;
    logic [WSEL_W-1:0]            dwr_sel;
    logic [WORD_W-1:0]            dwr_data, sel_word, beat_word;

    assign hit       = t_valid && (t_tag == r_tag);
    assign mem_fire  = mem_valid && mem_ready;
    assign last_beat = (beat == LAST_BEAT);
    assign sel_word  = line_bits[r_wsel*WORD_W +: WORD_W];
    assign beat_word = line_bits[beat*WORD_W +: WORD_W];

    dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(r_idx),
        .alloc_en(alloc_en), .alloc_tag(r_tag), .dirty_set(dirty_set),
        .line_valid(t_valid), .line_dirty(t_dirty), .line_tag(t_tag)
    );

    dmc_data_store #(.LINES(LINES), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) u_data (
        .clk(clk), .idx(r_idx), .wr_en(dwr_en), .wr_sel(dwr_sel),
        .wr_data(dwr_data), .line_bits(line_bits)
    );

    dmc_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .bump_hit(finish && !r_miss), .bump_miss(finish && r_miss),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    // Next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (cpu_req) nxt = ST_LOOKUP;
            ST_LOOKUP: begin
                if (hit)                                nxt = (r_we && !WRITE_BACK) ? ST_MEMWR : ST_IDLE;
                else if (r_we && !WRITE_ALLOC)          nxt = ST_MEMWR;
                else if (WRITE_BACK && t_valid && t_dirty) nxt = ST_EVICT;
                else                                    nxt = ST_FILL;
            end
            ST_EVICT:  if (mem_fire && last_beat) nxt = ST_FILL;
            ST_FILL:   if (mem_fire && last_beat) nxt = ST_LOOKUP;
            ST_MEMWR:  if (mem_fire) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        cpu_ready = 1'b0;
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {r_addr[ADDR_W-1:BYTE_OFF], {BYTE_OFF{1'b0}}};
        mem_wdata = r_wdata;
        dwr_en    = 1'b0;
        dwr_sel   = r_wsel;
        dwr_data  = r_wdata;
        alloc_en  = 1'b0;
        dirty_set = 1'b0;
        finish    = 1'b0;
        unique case (state)
            ST_IDLE:   cpu_ready = 1'b1;
            ST_LOOKUP: begin
                if (hit && r_we) begin
                    dwr_en    = 1'b1;
                    dirty_set = WRITE_BACK;
                end
                finish = hit && (!r_we || WRITE_BACK);
            end
            ST_EVICT: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {t_tag, r_idx, beat, {BYTE_OFF{1'b0}}};
                mem_wdata = beat_word;
            end
            ST_FILL: begin
                mem_valid = 1'b1;
                mem_addr  = {r_tag, r_idx, beat, {BYTE_OFF{1'b0}}};
                dwr_en    = mem_fire;
                dwr_sel   = beat;
                dwr_data  = mem_rdata;
                alloc_en  = mem_fire && last_beat;
            end
            ST_MEMWR: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                finish    = mem_fire;
            end
            default: ;
        endcase
    end

    // State and request registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            r_addr    <= '0;
            r_we      <= 1'b0;
            r_wdata   <= '0;
            r_miss    <= 1'b0;
            beat      <= '0;
            cpu_done  <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            state    <= nxt;
            cpu_done <= finish;
            if (state == ST_IDLE && cpu_req) begin
                r_addr  <= cpu_addr;
                r_we    <= cpu_we;
                r_wdata <= cpu_wdata;
                r_miss  <= 1'b0;
                beat    <= '0;
            end
            if (state == ST_LOOKUP && !hit) r_miss <= 1'b1;
            if (state == ST_LOOKUP && hit && !r_we) cpu_rdata <= sel_word;
            if ((state == ST_EVICT || state == ST_FILL) && mem_fire) beat <= beat + 1'b1;
        end
    end
endmodule

// File: rtl/dmc_checker.sv
`timescale 1ns/1ps
module dmc_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              cpu_done,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  miss_count
);
    logic [CNT_W:0] total;
    assign total = {1'b0, hit_count} + {1'b0, miss_count};

    assert_ready_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready) |=> !cpu_ready);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    assert_mem_in_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !cpu_ready);

    assert_mem_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

    assert_count_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> (total == $past(total) + {{CNT_W{1'b0}}, 1'b1}));

    assert_count_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_done |-> (total == $past(total)));
endmodule

bind dm_cache dmc_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
    .cpu_done(cpu_done), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .hit_count(hit_count),
    .miss_count(miss_count)
);

// File: tb/sim_dm_cache.sv
`timescale 1ns/1ps
module cache_lane #(
    parameter bit WB   = 1'b1,
    parameter bit WA   = 1'b1,
    parameter int SEED = 1
) (
    input  logic clk,
    input  logic rst_n,
    output int   checks,
    output int   fails,
    output logic finished
);
    localparam int NL = 16;

    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready, cpu_done;
    logic [31:0] cpu_rdata;
    logic        mem_valid, mem_we, mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [15:0] hit_count, miss_count;

    dm_cache #(.LINES(NL), .WRITE_BACK(WB), .WRITE_ALLOC(WA)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .mem_valid(mem_valid),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .hit_count(hit_count),
        .miss_count(miss_count)
    );

    logic [31:0] ram  [4096];
    logic [31:0] gold [4096];
    logic [31:0] log_a [4096];
    bit          log_w [4096];
    int          log_n = 0;
    int          n_chk = 0, n_fail = 0, p_chk = 0, p_fail = 0;
    bit          m_valid [NL];
    bit          m_dirty [NL];
    logic [31:0] m_tag   [NL];
    int          exp_hit = 0, exp_miss = 0;
    bit          stall_prev = 1'b0;
    logic [31:0] prev_addr = '0;
    bit          prev_we = 1'b0;

    assign mem_rdata = ram[mem_addr[13:2]];
    assign checks = n_chk + p_chk;
    assign fails  = n_fail + p_fail;

    function automatic logic [31:0] init_word(int i);
        return 32'hA500_0000 + 32'(i) * 32'h0001_0003;
    endfunction

    // Memory responder: random stalls, traffic log, hold check (R13)
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) ram[i] <= init_word(i);
            mem_ready  <= 1'b0;
            stall_prev <= 1'b0;
        end else begin
            if (stall_prev) begin
                p_chk++;
                if (!(mem_valid && mem_addr == prev_addr && mem_we == prev_we)) begin
                    p_fail++;
                    $display("FAIL R13 lane WB=%0d WA=%0d actual=%h expected=%h", WB, WA, mem_addr, prev_addr);
                end
            end
            begin
                bit rdy;
                rdy = ($urandom % 4) != 0;
                mem_ready  <= rdy;
                stall_prev <= mem_valid && !rdy;
                prev_addr  <= mem_addr;
                prev_we    <= mem_we;
                if (mem_valid && rdy) begin
                    log_a[log_n % 4096] <= mem_addr;
                    log_w[log_n % 4096] <= mem_we;
                    log_n <= log_n + 1;
                    if (mem_we) ram[mem_addr[13:2]] <= mem_wdata;
                end
            end
        end
    end

    task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s lane WB=%0d WA=%0d actual=%h expected=%h", r, WB, WA, act, expv);
        end
    endtask

    task automatic access(bit we, logic [31:0] a, logic [31:0] wd, string ovr);
        int          idx, base, en, w, got;
        bit          hit, evict;
        logic [31:0] tg, blk;
        logic [31:0] exp_a [12];
        bit          exp_w [12];
        string       lab;
        idx = int'(a[7:4]);
        tg  = a >> 8;
        blk = a & 32'hFFFF_FFF0;
        hit = m_valid[idx] && m_tag[idx] == tg;
        evict = 1'b0;
        en = 0;
        if (hit) begin
            if (we && !WB) begin exp_a[en] = a; exp_w[en] = 1'b1; en++; end
            if (we && WB) m_dirty[idx] = 1'b1;
            lab = we ? (WB ? "R7" : "R6") : "R4";
        end else if (we && !WA) begin
            exp_a[en] = a; exp_w[en] = 1'b1; en++;
            lab = "R10";
        end else begin
            if (WB && m_valid[idx] && m_dirty[idx]) begin
                evict = 1'b1;
                for (int k = 0; k < 4; k++) begin
                    exp_a[en] = (m_tag[idx] << 8) | 32'(idx << 4) | 32'(k << 2);
                    exp_w[en] = 1'b1; en++;
                end
            end
            for (int k = 0; k < 4; k++) begin
                exp_a[en] = blk + 32'(k * 4); exp_w[en] = 1'b0; en++;
            end
            if (we && !WB) begin exp_a[en] = a; exp_w[en] = 1'b1; en++; end
            m_valid[idx] = 1'b1;
            m_tag[idx]   = tg;
            m_dirty[idx] = we && WB;
            lab = evict ? "R8" : (we ? "R9" : "R5");
        end
        if (ovr != "") lab = ovr;
        if (hit) exp_hit++; else exp_miss++;
        if (we) gold[a[13:2]] = wd;

        @(negedge clk);
        base = log_n;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        w = 0;
        while (!cpu_done && w < 400) begin
            @(negedge clk);
            w++;
        end
        chk(cpu_done, "R11", 32'(cpu_done), 32'd1);
        chk(cpu_ready, "R11", 32'(cpu_ready), 32'd1);
        if (!we) chk(cpu_rdata == gold[a[13:2]], lab, cpu_rdata, gold[a[13:2]]);
        chk(32'(hit_count) == 32'(exp_hit), "R12", 32'(hit_count), 32'(exp_hit));
        chk(32'(miss_count) == 32'(exp_miss), "R12", 32'(miss_count), 32'(exp_miss));
        got = log_n - base;
        chk(got == en, lab, 32'(got), 32'(en));
        for (int i = 0; i < en && i < got; i++) begin
            chk(log_a[(base + i) % 4096] == exp_a[i] && log_w[(base + i) % 4096] == exp_w[i],
                lab, log_a[(base + i) % 4096], exp_a[i]);
        end
        if (!WB) chk(ram[a[13:2]] == gold[a[13:2]], "R6", ram[a[13:2]], gold[a[13:2]]);
    endtask

    initial begin
        finished = 1'b0;
        for (int i = 0; i < 4096; i++) gold[i] = init_word(i);
        for (int i = 0; i < NL; i++) begin m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = '0; end
        void'($urandom(SEED));
        wait (rst_n);
        @(negedge clk);
        chk(cpu_ready == 1'b1, "R2", 32'(cpu_ready), 32'd1);
        chk(mem_valid == 1'b0, "R2", 32'(mem_valid), 32'd0);
        chk(cpu_done == 1'b0, "R2", 32'(cpu_done), 32'd0);
        chk(hit_count == 16'd0 && miss_count == 16'd0, "R2", 32'(hit_count), 32'd0);
        // Directed corners
        access(1'b0, 32'h0000_0000, '0, "R3");    // tag 0 against invalid line
        access(1'b0, 32'h0000_0004, '0, "R4");
        access(1'b0, 32'h0000_001C, '0, "R5");
        access(1'b1, 32'h0000_0008, 32'hDEAD_0001, "");
        access(1'b0, 32'h0000_0008, '0, "R4");
        access(1'b0, 32'h0000_0100, '0, "R1");    // same index, new tag
        access(1'b0, 32'h0000_0018, '0, "R1");    // other index kept
        access(1'b0, 32'h0000_0008, '0, "");
        access(1'b1, 32'h0000_0208, 32'hBEEF_0002, "");
        access(1'b0, 32'h0000_0008, '0, "");
        access(1'b0, 32'h0000_0208, '0, "");
        // Constrained random traffic
        for (int n = 0; n < 300; n++) begin
            logic [31:0] ra;
            bit rw;
            ra = ($urandom % 512) << 2;
            rw = ($urandom % 3) == 0;
            access(rw, ra, $urandom, "");
        end
        finished = 1'b1;
    end
endmodule

module sim_dm_cache;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   c0, c1, c2, c3, f0, f1, f2, f3;
    logic d0, d1, d2, d3;
    int   cyc = 0;
    int   total_c, total_f;

    always #2.5 clk = ~clk;

    cache_lane #(.WB(1'b1), .WA(1'b1), .SEED(11)) lane_wb_wa (.clk(clk), .rst_n(rst_n), .checks(c0), .fails(f0), .finished(d0));
    cache_lane #(.WB(1'b1), .WA(1'b0), .SEED(23)) lane_wb_na (.clk(clk), .rst_n(rst_n), .checks(c1), .fails(f1), .finished(d1));
    cache_lane #(.WB(1'b0), .WA(1'b1), .SEED(37)) lane_wt_wa (.clk(clk), .rst_n(rst_n), .checks(c2), .fails(f2), .finished(d2));
    cache_lane #(.WB(1'b0), .WA(1'b0), .SEED(41)) lane_wt_na (.clk(clk), .rst_n(rst_n), .checks(c3), .fails(f3), .finished(d3));

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        while (!(d0 && d1 && d2 && d3) && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        @(negedge clk);
        total_c = c0 + c1 + c2 + c3;
        total_f = f0 + f1 + f2 + f3;
        if (!(d0 && d1 && d2 && d3)) begin
            total_c++;
            total_f++;
            $display("FAIL R11 watchdog actual=%0d expected=<150000 cycles", cyc);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total_c, total_f);
        $finish;
    end
endmodule